// File: doc/BRIEF.md
# Slow RC Oscillator Calibration Sequencer

This block is a hardware sequencer that trims a nominal 10 kHz RC oscillator and sets up a fractional divider, so that the divided oscillator output ticks at 1024 Hz. A measurement input supplies a period count. The count is the number of 12 MHz reference cycles that occur in 16 cycles of the RC oscillator, and it reads 19200 when the oscillator runs at exactly 10 kHz. Software pulses `start_i` and later sees a one-cycle `done_o`. Between these two events the block drives the oscillator's coarse trim and the divider setting on its own.

The run has two passes. The coarse pass takes a single period reading and turns it into a rounded step count, which it clamps to the trim range and writes to the 4-bit two's-complement trim output. The fine pass then averages eight readings and divides a fixed constant by that average. The result is a 5.11 fixed-point divider value. Every reading waits first for a settle interval, counted in reference clock cycles, because the period counter refreshes slowly and runs on its own timing.

Top module: `rc_cal_seq`

## Requirements
- R1: On an accepted start, one clock later, `tune_o` holds the trim reset value (0 by default), `cal_o` holds 0x5000 (divide by 10.0 in 5.11), `meas_slow_o` is 1 and `busy_o` is 1.
- R2: Each period reading waits at least `SETTLE_CYCLES` clock cycles from the preceding trim write or reading, so a full run lasts at least 9 × `SETTLE_CYCLES` cycles from start to done.
- R3: The coarse trim is ((19200 + 400) − period) / 800, with the quotient truncated toward zero. It is written to `tune_o` as 4-bit two's complement, so −1 appears as 4'hF.
- R4: The coarse trim is clamped to the range −8 to +7. It never wraps.
- R5: The fine pass takes 8 readings after the coarse trim has been applied and averages them as (sum + 4) / 8.
- R6: `cal_o` receives 384000000 / average, truncated toward zero and then cut to its low 16 bits. Bits 15:11 are the integer part and bits 10:0 the fraction.
- R7: `done_o` is high for exactly one cycle, in the cycle in which `cal_o` takes its result. `busy_o` is low from that cycle on.
- R8: An average of zero leaves `cal_o` at 0x5000. It raises `err_o` together with `done_o`, and `err_o` stays high until the next accepted start clears it.
- R9: A start pulse while `busy_o` is high is ignored. The trim is not reloaded, and the run ends with one `done_o` and the correct result.
- R10: After reset, `tune_o` = 0, `cal_o` = 0x5000, and `meas_slow_o`, `busy_o`, `done_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a calibration run (taken only when idle) |
| period_i | input | 16 | Reference cycles counted over 16 RC cycles |
| meas_slow_o | output | 1 | Selects the slow RC as the period counter's source |
| tune_o | output | 4 | Coarse trim to the RC oscillator, two's complement |
| cal_o | output | 16 | Fractional divider setting, 5.11 fixed point |
| busy_o | output | 1 | Calibration run in progress |
| done_o | output | 1 | One-cycle pulse when the run ends |
| err_o | output | 1 | Last run saw a zero average and left the divider unchanged |

## Verification
The oscillator model in the bench returns a period equal to a base value plus 800 per trim step. Because of this, the fine average differs from the coarse reading unless the trim is zero, which shows that the fine pass reads with the new trim in place. Base periods are chosen in pairs:
- 19200 and 20000 give trim zero, and 20000 also separates truncation toward zero from flooring.
- 21000 gives a negative step.
- 5000 and 40000 drive both clamps.
- 18400 and 17900 give small positive steps.

A fixed period of 3 forces a quotient wider than 16 bits, which exposes the truncation. A fixed period of 0 takes the zero-average path.

// File: rtl/rc_cal_pkg.sv
// Package: shared types for the slow RC calibration sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rc_cal_pkg;

    // Sequencer phases: idle, waiting on settle timer, averaging, dividing.
    typedef enum logic [1:0] {
        CAL_IDLE   = 2'd0,
        CAL_SETTLE = 2'd1,
        CAL_AVG    = 2'd2,
        CAL_DIV    = 2'd3
    } cal_state_t;

endpackage

// File: rtl/rc_settle_timer.sv
// Module: one-shot settle timer.
// Loading starts a countdown. The single-cycle expire pulse comes CYCLES+1
// clocks after the load. A new load restarts the count.
// Assumes: CYCLES >= 1.
module rc_settle_timer #(
    parameter int CYCLES = 51000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expire_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    // Countdown and expiry pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            run_q    <= 1'b0;
            expire_o <= 1'b0;
        end else begin
            expire_o <= 1'b0;
            if (load_i) begin
                cnt_q <= CW'(CYCLES - 1);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (cnt_q == '0) begin
                    run_q    <= 1'b0;
                    expire_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    // R2: a fresh load never expires on the very next cycle.
    a_r2_no_early_expire: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !expire_o);

    // R2: an expiry is always preceded by a running countdown.
    a_r2_expire_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> $past(run_q));
endmodule

// File: rtl/rc_sample_accum.sv
// Module: period sample accumulator with rounded mean.
// The sum is cleared on clear_i and adds sample_i on add_i. avg_o is the
// mean (sum + SAMPLES/2) / SAMPLES.
// Assumes: SAMPLES is a power of two and at most SAMPLES adds occur per clear.
module rc_sample_accum #(
    parameter int IN_W    = 16,
    parameter int SAMPLES = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            add_i,
    input  logic [IN_W-1:0] sample_i,
    output logic [IN_W-1:0] avg_o
);
    localparam int SH    = $clog2(SAMPLES);
    localparam int SUM_W = IN_W + SH;

    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] rounded;

    // Running sum of the accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n)       sum_q <= '0;
        else if (clear_i) sum_q <= '0;
        else if (add_i)   sum_q <= sum_q + SUM_W'(sample_i);
    end

    // Rounded mean: add half a step, then shift.
    always_comb begin
        rounded = sum_q + SUM_W'(SAMPLES / 2);
        avg_o   = IN_W'(rounded >> SH);
    end

    // R5: a sample add never shrinks the sum within one run.
    a_r5_sum_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (add_i && !clear_i) |=> sum_q >= $past(sum_q));

    // R5: a clear always yields an empty sum.
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> sum_q == '0);
endmodule

// File: rtl/rc_restoring_div.sv
// Module: multi-cycle restoring divider, one quotient bit per clock.
// The result appears NUM_W+1 clocks after start_i, marked by a one-cycle
// done_o. quot_o carries the low Q_W bits of the quotient.
// Assumes: den_i is nonzero at start; the caller guarantees this.
module rc_restoring_div #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 16,
    parameter int Q_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [Q_W-1:0]   quot_o
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] q_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   rem_n;
    logic             fits;

    // One restoring step: shift in the next dividend bit and try a subtract.
    always_comb begin
        trial = {rem_q, q_q[NUM_W-1]};
        fits  = trial >= {1'b0, den_q};
        rem_n = fits ? (trial - {1'b0, den_q}) : trial;
    end

    // Iteration control and quotient/remainder registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q    <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                q_q   <= num_i;
                rem_q <= '0;
                den_q <= den_i;
                cnt_q <= CNT_W'(NUM_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= rem_n[DEN_W-1:0];
                q_q   <= {q_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q  <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign quot_o = q_q[Q_W-1:0];

    // R6: the partial remainder always fits below the divisor width.
    a_r6_rem_fits: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> !rem_n[DEN_W]);

    // R6: a finished division leaves a remainder smaller than the divisor.
    a_r6_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> rem_q < den_q);
endmodule

// File: rtl/rc_cal_seq.sv
// Module: slow RC oscillator calibration sequencer (top).
// The coarse pass turns one period reading into a rounded, clamped trim
// step. The fine pass averages SAMPLES readings and divides CAL_NUMER by
// the average to get a 5.11 divider setting. Each reading follows a settle
// wait of SETTLE_CYCLES clocks.
// Assumes: period_i is stable around each read; SAMPLES is a power of two.
module rc_cal_seq
    import rc_cal_pkg::*;
#(
    parameter int PERIOD_W      = 16,
    parameter int TUNE_W        = 4,
    parameter int CAL_W         = 16,
    parameter int NUMER_W       = 32,
    parameter int SETTLE_CYCLES = 51000,
    parameter int SAMPLES       = 8,
    parameter int IDEAL_PERIOD  = 19200,
    parameter int STEP_PERIOD   = 800,
    parameter longint CAL_NUMER = 384000000,
    parameter int TUNE_INIT     = 0,
    parameter int CAL_INIT      = 'h5000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                meas_slow_o,
    output logic [TUNE_W-1:0]   tune_o,
    output logic [CAL_W-1:0]    cal_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o
);
    localparam int SCNT_W = $clog2(SAMPLES);
    localparam int DW     = PERIOD_W + 2;
    localparam logic [SCNT_W-1:0]   LAST_SAMPLE = SCNT_W'(SAMPLES - 1);
    localparam logic [TUNE_W-1:0]   TUNE_RST    = TUNE_W'(TUNE_INIT);
    localparam logic [CAL_W-1:0]    CAL_RST     = CAL_W'(CAL_INIT);
    localparam logic signed [DW-1:0] CENTER_S   = DW'(IDEAL_PERIOD + STEP_PERIOD / 2);
    localparam logic signed [DW-1:0] STEP_S     = DW'(STEP_PERIOD);
    localparam logic signed [DW-1:0] TMAX_S     = DW'((1 <<< (TUNE_W - 1)) - 1);
    localparam logic signed [DW-1:0] TMIN_S     = DW'(-(1 <<< (TUNE_W - 1)));
    localparam logic [NUMER_W-1:0]   NUMER      = NUMER_W'(CAL_NUMER);

    cal_state_t            state_q;
    logic                  coarse_q;
    logic [SCNT_W-1:0]     samp_q;
    logic                  tmr_load;
    logic                  tmr_expire;
    logic                  acc_clear;
    logic                  acc_add;
    logic [PERIOD_W-1:0]   avg;
    logic                  div_start;
    logic                  div_done;
    logic [CAL_W-1:0]      quot;
    logic signed [DW-1:0]  diff_s;
    logic signed [DW-1:0]  step_s;
    logic [TUNE_W-1:0]     tune_next;
    logic                  accept;

    // Start is taken only while idle.
    assign accept = (state_q == CAL_IDLE) && start_i;
    assign busy_o = (state_q != CAL_IDLE);

    // Coarse step: centre minus period, divided toward zero, then clamped.
    always_comb begin
        diff_s = CENTER_S - $signed({2'b00, period_i});
        step_s = diff_s / STEP_S;
        if (step_s > TMAX_S)      tune_next = TMAX_S[TUNE_W-1:0];
        else if (step_s < TMIN_S) tune_next = TMIN_S[TUNE_W-1:0];
        else                      tune_next = step_s[TUNE_W-1:0];
    end

    // Strobes to the timer, accumulator and divider.
    always_comb begin
        tmr_load  = accept ||
                    ((state_q == CAL_SETTLE) && tmr_expire &&
                     (coarse_q || (samp_q != LAST_SAMPLE)));
        acc_clear = accept;
        acc_add   = (state_q == CAL_SETTLE) && tmr_expire && !coarse_q;
        div_start = (state_q == CAL_AVG) && (avg != '0);
    end

    // Sequencer and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= CAL_IDLE;
            coarse_q    <= 1'b0;
            samp_q      <= '0;
            tune_o      <= TUNE_RST;
            cal_o       <= CAL_RST;
            meas_slow_o <= 1'b0;
            done_o      <= 1'b0;
            err_o       <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                CAL_IDLE: begin
                    if (start_i) begin
                        tune_o      <= TUNE_RST;
                        cal_o       <= CAL_RST;
                        meas_slow_o <= 1'b1;
                        err_o       <= 1'b0;
                        coarse_q    <= 1'b1;
                        samp_q      <= '0;
                        state_q     <= CAL_SETTLE;
                    end
                end
                CAL_SETTLE: begin
                    if (tmr_expire) begin
                        if (coarse_q) begin
                            tune_o   <= tune_next;
                            coarse_q <= 1'b0;
                        end else if (samp_q == LAST_SAMPLE) begin
                            state_q <= CAL_AVG;
                        end else begin
                            samp_q <= samp_q + 1'b1;
                        end
                    end
                end
                CAL_AVG: begin
                    if (avg == '0) begin
                        err_o   <= 1'b1;
                        done_o  <= 1'b1;
                        state_q <= CAL_IDLE;
                    end else begin
                        state_q <= CAL_DIV;
                    end
                end
                CAL_DIV: begin
                    if (div_done) begin
                        cal_o   <= quot;
                        done_o  <= 1'b1;
                        state_q <= CAL_IDLE;
                    end
                end
                default: state_q <= CAL_IDLE;
            endcase
        end
    end

    rc_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .expire_o (tmr_expire)
    );

    rc_sample_accum #(.IN_W(PERIOD_W), .SAMPLES(SAMPLES)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (acc_clear),
        .add_i    (acc_add),
        .sample_i (period_i),
        .avg_o    (avg)
    );

    rc_restoring_div #(.NUM_W(NUMER_W), .DEN_W(PERIOD_W), .Q_W(CAL_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (NUMER),
        .den_i   (avg),
        .done_o  (div_done),
        .quot_o  (quot)
    );

    // R7: done is a single-cycle pulse and the block is idle after it.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R1: an accepted start reloads trim and divider and selects slow RC.
    a_r1_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (tune_o == TUNE_RST) && (cal_o == CAL_RST) && meas_slow_o && busy_o);

    // R8: while the error flag is up the divider keeps its reset setting.
    a_r8_err_keeps_cal: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> cal_o == CAL_RST);

    // R9: a start during the fine pass leaves the trim untouched.
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o && !coarse_q) |=> $stable(tune_o));
endmodule

// File: tb/tb_rc_cal_seq.sv
`timescale 1ns/1ps
module tb_rc_cal_seq;
    localparam int SETTLE = 16;
    localparam int NV     = 9;
    // Stimulus table: mode 0 = period tracks trim (base + 800*tune), 1 = fixed.
    localparam int V_MODE [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1};
    localparam int V_BASE [NV] = '{19200, 20000, 21000, 5000, 40000, 18400, 17900, 3, 0};
    localparam int V_TUNE [NV] = '{0, 0, -1, 7, -8, 1, 2, 7, 7};
    localparam int V_CAL  [NV] = '{20000, 19200, 19009, 36226, 11428, 20000, 19692, 8192, 20480};
    localparam int V_ERR  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] period;
    logic        meas_slow, busy, done, err;
    logic [3:0]  tune;
    logic [15:0] cal;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    int mode  = 0;
    int base  = 19200;

    always #4 clk = ~clk;

    rc_cal_seq #(.SETTLE_CYCLES(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .period_i(period),
        .meas_slow_o(meas_slow), .tune_o(tune), .cal_o(cal),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    // Oscillator model: each trim step moves the period by 800.
    always_comb begin
        int p;
        p = (mode == 1) ? base : base + $signed(tune) * 800;
        if (p < 0) p = 0;
        if (p > 65535) p = 65535;
        period = 16'(p);
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(output int lat, output bit seen);
        lat  = 0;
        seen = 1'b0;
        for (int i = 0; i < 5000 && !seen; i++) begin
            @(negedge clk);
            lat++;
            if (done) seen = 1'b1;
        end
    endtask

    initial begin
        int  lat;
        bit  seen;
        int  extra;
        rst_n = 1'b0;
        start = 1'b0;
        repeat (4) @(negedge clk);
        // R10: reset state
        chk("R10 tune", int'(tune), 0);
        chk("R10 cal", int'(cal), 'h5000);
        chk("R10 flags", int'({meas_slow, busy, done, err}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: one full calibration per vector.
        for (int v = 0; v < NV; v++) begin
            mode = V_MODE[v];
            base = V_BASE[v];
            pulse_start();
            // R1: reload and slow-RC select one clock after start
            chk($sformatf("R1 tune v%0d", v), int'(tune), 0);
            chk($sformatf("R1 cal v%0d", v), int'(cal), 'h5000);
            chk($sformatf("R1 meas/busy v%0d", v), int'({meas_slow, busy}), 3);
            chk($sformatf("R8 err cleared v%0d", v), int'(err), 0);
            wait_done(lat, seen);
            chk($sformatf("R7 done seen v%0d", v), int'(seen), 1);
            chk($sformatf("R2 run length v%0d", v), int'(lat >= 9 * SETTLE), 1);
            chk($sformatf("R3 R4 tune v%0d", v), int'($signed(tune)), V_TUNE[v]);
            chk($sformatf("R5 R6 cal v%0d", v), int'(cal), V_CAL[v]);
            chk($sformatf("R8 err v%0d", v), int'(err), V_ERR[v]);
            @(negedge clk);
            chk($sformatf("R7 single pulse v%0d", v), int'({done, busy}), 0);
            if (V_ERR[v] != 0) begin
                repeat (5) @(negedge clk);
                chk("R8 err held", int'(err), 1);
                chk("R8 cal held", int'(cal), 'h5000);
            end
        end

        // R8: error clears on the next accepted start
        mode = 0;
        base = 19200;
        pulse_start();
        chk("R8 err clears on start", int'(err), 0);
        wait_done(lat, seen);
        chk("R8 recovery cal", int'(cal), 20000);

        // R9: start during a run is ignored
        mode = 0;
        base = 5000;
        pulse_start();
        for (int i = 0; i < 200 && tune != 4'd7; i++) @(negedge clk);
        chk("R9 coarse applied", int'($signed(tune)), 7);
        pulse_start();
        chk("R9 trim kept", int'($signed(tune)), 7);
        chk("R9 still busy", int'(busy), 1);
        wait_done(lat, seen);
        chk("R9 done once", int'(seen), 1);
        chk("R9 result", int'(cal), 36226);
        extra = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R9 no second done", extra, 0);

        // R10: synchronous reset mid-run returns to reset state
        pulse_start();
        repeat (3 * SETTLE) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 mid-run reset tune", int'(tune), 0);
        chk("R10 mid-run reset busy", int'({busy, meas_slow}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule